// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Output Aliases

This block is a 32-pin general-purpose I/O port reached through a plain 32-bit register interface. The interface has an address, a write enable, write data and combinational read data. Each register has one bit per pin.

The port keeps three pieces of state:
- an output latch, which drives the pad output values;
- a direction register, which drives the pad output enables;
- a synchronised copy of the pad inputs.

Three write-only alias addresses change the output latch in a single write, with no read-modify-write. One alias raises selected bits, one lowers them and one inverts them.

Software reads the level of an output pin from the output latch register. Software reads the level of an input pin from the input register. The input register shows the pad levels after a two-flop synchroniser.

Top module: `gpioPort`

## Requirements
- R1: An active-low asynchronous reset clears the output latch and the direction register. After reset, `padOut`, `padOutEn` and every readable register return 0.
- R2: A write to byte offset 0x00 loads the output latch. A read of 0x00 returns the latch, and `padOut` shows the new value from the clock edge that takes the write.
- R3: A write to offset 0x04 sets to 1 every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x08 clears to 0 every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R5: A write to offset 0x0C inverts every latch bit whose write-data bit is 1. A toggle write of all zeros leaves the latch unchanged.
- R6: Offset 0x14 is the read/write direction register, where bit value 1 means output. `padOutEn` equals this register, and it changes only on a write to 0x14.
- R7: A read of offset 0x10 returns `padIn` as sampled two clock edges earlier. Writes to 0x10 change no state.
- R8: Reads of the alias offsets 0x04, 0x08 and 0x0C return 0. Reads of any other offset, including any offset whose two low bits are not 0, also return 0. Writes to such offsets change no state.
- R9: A read of 0x00 returns the latch value whatever level is present on `padIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| padIn | input | 32 | Pad input levels (asynchronous) |
| padOut | output | 32 | Pad output values (output latch) |
| padOutEn | output | 32 | Pad output enables (direction register) |

## Verification
A wrong latch bit is visible on `padOut` on the clock edge after the faulty write, with no need for a read. A wrong direction bit is likewise visible on `padOutEn` at once. A synchroniser with the wrong depth or the wrong reset shows up as read data at 0x10 that is one edge early, one edge late, or stale, while the pads change on every cycle. A decode fault, such as an alias that answers reads or a misaligned offset that reaches a register, shows in the same cycle in read data. It shows on the next edge if it changes the latch.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  // byte offsets of the register map
  localparam int OFS_DATA = 'h00;
  localparam int OFS_SET  = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int OFS_TGL  = 'h0C;
  localparam int OFS_IN   = 'h10;
  localparam int OFS_DIR  = 'h14;

  // one-cycle write strobes from decode to datapath
  typedef struct packed {
    logic ldData;
    logic setBits;
    logic clrBits;
    logic tglBits;
    logic ldDir;
  } wrStrobes_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_DATA = 2'd1,
    RD_IN   = 2'd2,
    RD_DIR  = 2'd3
  } rdSel_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output wrStrobes_t        strb,
  output rdSel_t            rdSel
);
  logic hitData, hitSet, hitClr, hitTgl, hitIn, hitDir;

  always_comb begin
    hitData = (regAddr == ADDR_W'(OFS_DATA));
    hitSet  = (regAddr == ADDR_W'(OFS_SET));
    hitClr  = (regAddr == ADDR_W'(OFS_CLR));
    hitTgl  = (regAddr == ADDR_W'(OFS_TGL));
    hitIn   = (regAddr == ADDR_W'(OFS_IN));
    hitDir  = (regAddr == ADDR_W'(OFS_DIR));
  end

  always_comb begin
    strb.ldData  = regWrEn && hitData;
    strb.setBits = regWrEn && hitSet;
    strb.clrBits = regWrEn && hitClr;
    strb.tglBits = regWrEn && hitTgl;
    strb.ldDir   = regWrEn && hitDir;
  end

  always_comb begin
    if (hitData)     rdSel = RD_DATA;
    else if (hitIn)  rdSel = RD_IN;
    else if (hitDir) rdSel = RD_DIR;
    else             rdSel = RD_ZERO;
  end
endmodule

// File: rtl/gpioSync.sv
module gpioSync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPortPkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobes_t      strb,
  input  rdSel_t          rdSel,
  input  logic [PINS-1:0] wrData,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOutEn,
  output logic [PINS-1:0] rdData
);
  logic [PINS-1:0] outLatch, outNext;
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] inSample;

  // at most one strobe is active per cycle (single decoded address)
  always_comb begin
    outNext = outLatch;
    if (strb.ldData)  outNext = wrData;
    if (strb.setBits) outNext = outLatch | wrData;
    if (strb.clrBits) outNext = outLatch & ~wrData;
    if (strb.tglBits) outNext = outLatch ^ wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outLatch <= '0;
    else       outLatch <= outNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dirReg <= '0;
    else if (strb.ldDir) dirReg <= wrData;
  end

  gpioSync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (inSample)
  );

  always_comb begin
    unique case (rdSel)
      RD_DATA: rdData = outLatch;
      RD_IN:   rdData = inSample;
      RD_DIR:  rdData = dirReg;
      default: rdData = '0;
    endcase
  end

  assign padOut   = outLatch;
  assign padOutEn = dirReg;
endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PINS-1:0]   regWrData,
  output logic [PINS-1:0]   regRdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOutEn
);
  wrStrobes_t strb;
  rdSel_t     rdSel;

  gpioCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  gpioDatapath #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .rdData   (regRdData)
  );
endmodule

// File: rtl/gpioPortChecker.sv
module gpioPortChecker #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [PINS-1:0]   regWrData,
  input logic [PINS-1:0]   regRdData,
  input logic [PINS-1:0]   padIn,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOutEn
);
  logic [1:0] edgesOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgesOut <= '0;
    else if (edgesOut != 2'd3) edgesOut <= edgesOut + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (padOut == '0 && padOutEn == '0));

  // R3
  set_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h04)) |=>
      ((padOut & $past(regWrData)) == $past(regWrData)) &&
      ((padOut & ~$past(regWrData)) == ($past(padOut) & ~$past(regWrData))));

  // R4
  clr_lowers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h08)) |=>
      ((padOut & $past(regWrData)) == '0) &&
      ((padOut & ~$past(regWrData)) == ($past(padOut) & ~$past(regWrData))));

  // R5
  tgl_inverts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h0C)) |=>
      (padOut == ($past(padOut) ^ $past(regWrData))));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'('h14)) |=> $stable(padOutEn));

  // R7
  in_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2 && regAddr == ADDR_W'('h10)) |->
      (regRdData == $past(padIn, 2)));

  // R8
  alias_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h04) || regAddr == ADDR_W'('h08) ||
     regAddr == ADDR_W'('h0C)) |-> (regRdData == '0));

  // R9
  data_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h00)) |-> (regRdData == padOut));
endmodule

bind gpioPort gpioPortChecker #(.PINS(PINS), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOutEn  (padOutEn)
);

// File: tb/tb_gpioPort.sv
`timescale 1ns/1ps
module tb_gpioPort;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOutEn;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // reference state
  logic [31:0] mOut = '0;
  logic [31:0] mDir = '0;
  logic [31:0] padHist[$];

  always #4 clk = ~clk;  // 125 MHz

  gpioPort dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOut = '0;
      mDir = '0;
      padHist.delete();
    end else begin
      if (regWrEn) begin
        case (regAddr)
          5'h00: mOut = regWrData;
          5'h04: mOut = mOut | regWrData;
          5'h08: mOut = mOut & ~regWrData;
          5'h0C: mOut = mOut ^ regWrData;
          5'h14: mDir = regWrData;
          default: ;
        endcase
      end
      padHist.push_back(padIn);
      if (padHist.size() > 2) void'(padHist.pop_front());
    end
  end

  function automatic logic [31:0] expRead(logic [4:0] a);
    case (a)
      5'h00: return mOut;
      5'h10: return (padHist.size() == 2) ? padHist[0] : 32'h0;
      5'h14: return mDir;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  // compare on every falling edge; inputs move 1 ns later
  always @(negedge clk) begin
    chk(curReq, "regRdData", regRdData, expRead(regAddr));
    chk("R2", "padOut", padOut, mOut);
    chk("R6", "padOutEn", padOutEn, mDir);
  end

  task automatic access(logic [4:0] a, logic we, logic [31:0] d, string req);
    @(negedge clk); #1;
    curReq = req; regAddr = a; regWrEn = we; regWrData = d;
  endtask

  task automatic idle(logic [4:0] a, string req, int n);
    for (int i = 0; i < n; i++) access(a, 1'b0, 32'h0, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state on all readable offsets
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    idle(5'h00, "R1", 2);
    idle(5'h14, "R1", 2);
    idle(5'h10, "R1", 2);
    // R2: load latch
    padIn = 32'h1234_5678;
    access(5'h00, 1, 32'hA5A5_0F0F, "R2");
    idle(5'h00, "R2", 2);
    access(5'h00, 1, 32'h0000_0001, "R2");
    idle(5'h00, "R2", 1);
    access(5'h00, 1, 32'hA5A5_0F0F, "R2");
    // R3: set alias
    access(5'h04, 1, 32'h0000_FFFF, "R3");
    idle(5'h00, "R3", 2);
    access(5'h04, 1, 32'h0, "R3");
    idle(5'h00, "R3", 1);
    // R4: clear alias
    access(5'h08, 1, 32'hF0F0_0000, "R4");
    idle(5'h00, "R4", 2);
    access(5'h08, 1, 32'h0, "R4");
    idle(5'h00, "R4", 1);
    // R5: toggle alias, all ones then all zeros
    access(5'h0C, 1, 32'hFFFF_FFFF, "R5");
    idle(5'h00, "R5", 1);
    access(5'h0C, 1, 32'h0, "R5");
    idle(5'h00, "R5", 1);
    access(5'h0C, 1, 32'h8000_0001, "R5");
    idle(5'h00, "R5", 1);
    // R6: direction register
    access(5'h14, 1, 32'hFFFF_0000, "R6");
    idle(5'h14, "R6", 2);
    access(5'h14, 1, 32'h0F0F_F0F0, "R6");
    idle(5'h14, "R6", 1);
    // R7: input sampled through two flops, pads changing every cycle
    for (int i = 0; i < 12; i++) begin
      access(5'h10, 0, 32'h0, "R7");
      padIn = 32'h9E37_79B9 * (i + 1);
    end
    idle(5'h10, "R7", 3);
    access(5'h10, 1, 32'hDEAD_BEEF, "R7");
    idle(5'h00, "R7", 1);
    idle(5'h14, "R7", 1);
    // R8: alias and unmapped reads, unmapped writes
    idle(5'h04, "R8", 1);
    idle(5'h08, "R8", 1);
    idle(5'h0C, "R8", 1);
    idle(5'h18, "R8", 1);
    idle(5'h01, "R8", 1);
    access(5'h18, 1, 32'hFFFF_FFFF, "R8");
    access(5'h02, 1, 32'hFFFF_FFFF, "R8");
    access(5'h15, 1, 32'hFFFF_FFFF, "R8");
    idle(5'h00, "R8", 1);
    idle(5'h14, "R8", 1);
    // R9: latch readback independent of pad levels
    padIn = ~padOut;
    idle(5'h00, "R9", 3);
    padIn = padOut;
    idle(5'h00, "R9", 2);
    // R1: reset from a non-zero state
    @(negedge clk); #1 rstN = 0; regWrEn = 0; curReq = "R1";
    @(negedge clk); #1 rstN = 1;
    idle(5'h00, "R1", 1);
    idle(5'h14, "R1", 1);
    idle(5'h10, "R1", 1);
    idle(5'h00, "R1", 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule